// File: doc/BRIEF.md
# Strided Banked Vector Load Unit

This block fetches one vector of elements from a word-interleaved memory split into independent banks and writes the elements into consecutive slots of a destination vector register. A single address generator produces at most one element address per cycle. In strided mode each address is the previous address plus a stride, starting at a base. In gather mode each address is the base plus one entry of an index vector. The length comes from a vector-length input. Values above the register capacity are clamped to that capacity.

Every bank is single-ported and has a fixed access latency. The unit keeps a busy countdown for each bank. It holds issue back only while the bank of the next element is still occupied. Elements are never skipped or reordered. When the stride and the bank count share no factor, one element issues every cycle. Every access has the same latency, so responses come back in issue order. The writeback stage numbers them in that order and raises a one-cycle completion pulse.

Top module: `vec_load_unit`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `mem_req_valid_o` and `vreg_we_o` are all low.
- R2: In strided mode (`gather_i` = 0), element i is requested at address `base_i + i*stride_i` modulo 2^AW. Wrap past the top of the address space is allowed.
- R3: The bank of an address is its low log2(NBANK) bits. No bank receives a second request within LAT cycles of its previous request.
- R4: Requests go out in element order, exactly once each. Element i is requested at the earliest cycle that is both later than the request for element i-1 and at least LAT cycles after the previous request to its bank. The first request is sampled on the edge after the one that accepts `start_i`.
- R5: With a stride that has no common factor with NBANK, requests go out on consecutive cycles. `done_o` then rises VLEN+LAT+1 edges after the start edge.
- R6: The k-th write (`vreg_we_o` high) carries `vreg_idx_o` = k and the data of the k-th response.
- R7: `done_o` is high for exactly one cycle, on the cycle after the last write, and `busy_o` is already low in that cycle.
- R8: In gather mode (`gather_i` = 1), element i is requested at `base_i + idx_vec_i[i*AW +: AW]` modulo 2^AW.
- R9: A length of 0 produces no memory request, and `done_o` rises one edge after the start edge.
- R10: A length greater than MAXV is treated as MAXV.
- R11: `start_i` is ignored while `busy_o` is high. The running load keeps its parameters and completes with a single done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a load (accepted only when idle) |
| gather_i | input | 1 | 1 selects indexed addressing, 0 selects strided |
| base_i | input | AW | Base word address |
| stride_i | input | AW | Word distance between successive elements |
| vlen_i | input | $clog2(MAXV+1) | Number of elements to load |
| idx_vec_i | input | MAXV*AW | Index vector, entry i at bits [i*AW +: AW] |
| mem_req_valid_o | output | 1 | Element request issued this cycle |
| mem_req_addr_o | output | AW | Word address of the request |
| mem_rsp_valid_i | input | 1 | Response data valid |
| mem_rsp_data_i | input | DW | Response data |
| vreg_we_o | output | 1 | Register slot write enable |
| vreg_idx_o | output | $clog2(MAXV) | Destination element slot |
| vreg_data_o | output | DW | Data written to the slot |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Load in progress |

## Verification
The hardest condition to reach is a load whose address stream revisits a bank before that bank's latency has expired. In that case issue must stall for the right number of cycles and then resume without dropping or reordering elements. The stimulus gets there in three ways: a stride of 2, which cycles through only half the banks; a stride of 0 and a stride of 16, which keep hitting one bank; and a gather whose quadratic indices collide irregularly. The request cycles are compared against a schedule built from the bank-latency rule. A second start pulse in the middle of a load checks that a busy unit ignores new commands.

// File: rtl/vlu_pkg.sv
package vlu_pkg;
    localparam int VLU_AW   = 16;
    localparam int VLU_DW   = 32;
    localparam int VLU_NB   = 16;
    localparam int VLU_LAT  = 11;
    localparam int VLU_MAXV = 16;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ISSUE = 2'd1,
        PH_DRAIN = 2'd2
    } vlu_phase_e;
endpackage

// File: rtl/vlu_addr_gen.sv
module vlu_addr_gen #(
    parameter int AW   = vlu_pkg::VLU_AW,
    parameter int MAXV = vlu_pkg::VLU_MAXV,
    localparam int IW  = $clog2(MAXV)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               step_i,
    input  logic               gather_i,
    input  logic [AW-1:0]      base_i,
    input  logic [AW-1:0]      stride_i,
    input  logic [MAXV*AW-1:0] idx_vec_i,
    input  logic [IW-1:0]      elem_i,
    output logic [AW-1:0]      addr_o
);
    typedef struct packed {
        logic               gather;
        logic [AW-1:0]      base;
        logic [AW-1:0]      stride;
        logic [AW-1:0]      acc;
        logic [MAXV*AW-1:0] idx;
    } ag_st_t;

    ag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.gather = gather_i;
            st_d.base   = base_i;
            st_d.stride = stride_i;
            st_d.acc    = base_i;
            st_d.idx    = idx_vec_i;
        end else if (step_i) begin
            st_d.acc = st_q.acc + st_q.stride;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o = st_q.gather ? (st_q.base + st_q.idx[elem_i*AW +: AW]) : st_q.acc;

    p_stride_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && !st_q.gather) |=> (addr_o == $past(addr_o) + $past(st_q.stride)))
        else $error("strided address did not advance by the stride");
endmodule

// File: rtl/vlu_bank_track.sv
module vlu_bank_track #(
    parameter int NBANK = vlu_pkg::VLU_NB,
    parameter int LAT   = vlu_pkg::VLU_LAT,
    localparam int BW   = $clog2(NBANK),
    localparam int CW   = $clog2(LAT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_i,
    input  logic [BW-1:0] issue_bank_i,
    input  logic [BW-1:0] query_bank_i,
    output logic          free_o
);
    logic [CW-1:0]    cnt_q [NBANK];
    logic [CW-1:0]    cnt_d [NBANK];
    logic [NBANK-1:0] fresh;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        always_comb begin
            if (issue_i && (issue_bank_i == BW'(b)))
                cnt_d[b] = CW'(LAT - 1);
            else if (cnt_q[b] != '0)
                cnt_d[b] = cnt_q[b] - CW'(1);
            else
                cnt_d[b] = cnt_q[b];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) cnt_q[b] <= '0;
            else        cnt_q[b] <= cnt_d[b];
        end

        assign fresh[b] = (cnt_q[b] == CW'(LAT - 1));
    end

    assign free_o = (cnt_q[query_bank_i] == '0);

    p_port_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |-> (cnt_q[issue_bank_i] == '0))
        else $error("request sent to a bank that is still busy");

    p_one_fresh_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(fresh) <= 1)
        else $error("more than one bank started in the same cycle");
endmodule

// File: rtl/vlu_wback.sv
module vlu_wback #(
    parameter int DW   = vlu_pkg::VLU_DW,
    parameter int MAXV = vlu_pkg::VLU_MAXV,
    localparam int LW  = $clog2(MAXV + 1),
    localparam int IW  = $clog2(MAXV)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm_i,
    input  logic [LW-1:0] target_i,
    input  logic          rsp_valid_i,
    input  logic [DW-1:0] rsp_data_i,
    output logic          we_o,
    output logic [IW-1:0] idx_o,
    output logic [DW-1:0] data_o,
    output logic          fin_o,
    output logic          done_o
);
    typedef struct packed {
        logic          active;
        logic [LW-1:0] cnt;
        logic [LW-1:0] target;
        logic          we;
        logic [IW-1:0] idx;
        logic [DW-1:0] data;
        logic          done;
    } wb_st_t;

    wb_st_t st_d, st_q;

    assign fin_o = st_q.active && (st_q.cnt == st_q.target);

    always_comb begin
        st_d      = st_q;
        st_d.we   = 1'b0;
        st_d.done = 1'b0;
        if (arm_i) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
            st_d.target = target_i;
        end else if (fin_o) begin
            st_d.active = 1'b0;
            st_d.done   = 1'b1;
        end else if (st_q.active && rsp_valid_i) begin
            st_d.we   = 1'b1;
            st_d.idx  = st_q.cnt[IW-1:0];
            st_d.data = rsp_data_i;
            st_d.cnt  = st_q.cnt + LW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign we_o   = st_q.we;
    assign idx_o  = st_q.idx;
    assign data_o = st_q.data;
    assign done_o = st_q.done;

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o)
        else $error("done held longer than one cycle");

    p_rsp_expected_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_i |-> (st_q.active && (st_q.cnt < st_q.target)))
        else $error("response arrived with no element outstanding");

    p_done_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !we_o)
        else $error("write coincided with done");
endmodule

// File: rtl/vec_load_unit.sv
module vec_load_unit #(
    parameter int AW    = vlu_pkg::VLU_AW,
    parameter int DW    = vlu_pkg::VLU_DW,
    parameter int NBANK = vlu_pkg::VLU_NB,
    parameter int LAT   = vlu_pkg::VLU_LAT,
    parameter int MAXV  = vlu_pkg::VLU_MAXV,
    localparam int LW   = $clog2(MAXV + 1),
    localparam int IW   = $clog2(MAXV),
    localparam int BW   = $clog2(NBANK)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               gather_i,
    input  logic [AW-1:0]      base_i,
    input  logic [AW-1:0]      stride_i,
    input  logic [LW-1:0]      vlen_i,
    input  logic [MAXV*AW-1:0] idx_vec_i,
    output logic               mem_req_valid_o,
    output logic [AW-1:0]      mem_req_addr_o,
    input  logic               mem_rsp_valid_i,
    input  logic [DW-1:0]      mem_rsp_data_i,
    output logic               vreg_we_o,
    output logic [IW-1:0]      vreg_idx_o,
    output logic [DW-1:0]      vreg_data_o,
    output logic               done_o,
    output logic               busy_o
);
    import vlu_pkg::*;

    typedef struct packed {
        vlu_phase_e    phase;
        logic [LW-1:0] vlen;
        logic [LW-1:0] cnt;
    } top_st_t;

    top_st_t       st_d, st_q;
    logic [LW-1:0] vlen_eff;
    logic          arm, load, fire, bank_free, wb_fin;
    logic [AW-1:0] addr;

    assign vlen_eff = (vlen_i > LW'(MAXV)) ? LW'(MAXV) : vlen_i;

    always_comb begin
        st_d = st_q;
        arm  = 1'b0;
        load = 1'b0;
        fire = (st_q.phase == PH_ISSUE) && bank_free;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.vlen  = vlen_eff;
                    st_d.cnt   = '0;
                    arm        = 1'b1;
                    load       = 1'b1;
                    st_d.phase = (vlen_eff == '0) ? PH_DRAIN : PH_ISSUE;
                end
            end
            PH_ISSUE: begin
                if (fire) begin
                    st_d.cnt = st_q.cnt + LW'(1);
                    if ((st_q.cnt + LW'(1)) == st_q.vlen) st_d.phase = PH_DRAIN;
                end
            end
            PH_DRAIN: begin
                if (wb_fin) st_d.phase = PH_IDLE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{phase: PH_IDLE, vlen: '0, cnt: '0};
        else        st_q <= st_d;
    end

    vlu_addr_gen #(.AW(AW), .MAXV(MAXV)) i_agen (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .step_i    (fire),
        .gather_i  (gather_i),
        .base_i    (base_i),
        .stride_i  (stride_i),
        .idx_vec_i (idx_vec_i),
        .elem_i    (st_q.cnt[IW-1:0]),
        .addr_o    (addr)
    );

    vlu_bank_track #(.NBANK(NBANK), .LAT(LAT)) i_banks (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue_i      (fire),
        .issue_bank_i (addr[BW-1:0]),
        .query_bank_i (addr[BW-1:0]),
        .free_o       (bank_free)
    );

    vlu_wback #(.DW(DW), .MAXV(MAXV)) i_wb (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_i       (arm),
        .target_i    (vlen_eff),
        .rsp_valid_i (mem_rsp_valid_i),
        .rsp_data_i  (mem_rsp_data_i),
        .we_o        (vreg_we_o),
        .idx_o       (vreg_idx_o),
        .data_o      (vreg_data_o),
        .fin_o       (wb_fin),
        .done_o      (done_o)
    );

    assign mem_req_valid_o = fire;
    assign mem_req_addr_o  = addr;
    assign busy_o          = (st_q.phase != PH_IDLE);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_req_valid_o)
        else $error("request while idle");

    p_zero_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (vlen_i == '0)) |=> !mem_req_valid_o)
        else $error("zero-length load issued a request");

    p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(st_q.vlen))
        else $error("start accepted while busy");

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o)
        else $error("busy still high during done");
endmodule

// File: tb/test_vec_load_unit.sv
module test_vec_load_unit;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 16;
    localparam int DW   = 32;
    localparam int NB   = 16;
    localparam int LAT  = 11;
    localparam int MAXV = 16;
    localparam int LW   = $clog2(MAXV + 1);
    localparam int IW   = $clog2(MAXV);
    localparam int LOGN = 64;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start_i = 1'b0;
    logic               gather_i = 1'b0;
    logic [AW-1:0]      base_i = '0;
    logic [AW-1:0]      stride_i = '0;
    logic [LW-1:0]      vlen_i = '0;
    logic [MAXV*AW-1:0] idx_vec_i = '0;
    logic               mem_req_valid_o;
    logic [AW-1:0]      mem_req_addr_o;
    logic               mem_rsp_valid_i;
    logic [DW-1:0]      mem_rsp_data_i;
    logic               vreg_we_o;
    logic [IW-1:0]      vreg_idx_o;
    logic [DW-1:0]      vreg_data_o;
    logic               done_o;
    logic               busy_o;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    vec_load_unit i_vec_load_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .gather_i(gather_i),
        .base_i(base_i), .stride_i(stride_i), .vlen_i(vlen_i), .idx_vec_i(idx_vec_i),
        .mem_req_valid_o(mem_req_valid_o), .mem_req_addr_o(mem_req_addr_o),
        .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_data_i(mem_rsp_data_i),
        .vreg_we_o(vreg_we_o), .vreg_idx_o(vreg_idx_o), .vreg_data_o(vreg_data_o),
        .done_o(done_o), .busy_o(busy_o)
    );

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        return {a ^ 16'hA5C3, a};
    endfunction

    // fixed-latency banked memory model
    logic          pv [LAT];
    logic [AW-1:0] pa [LAT];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < LAT; k++) pv[k] <= 1'b0;
        end else begin
            pv[0] <= mem_req_valid_o;
            pa[0] <= mem_req_addr_o;
            for (int k = 1; k < LAT; k++) begin
                pv[k] <= pv[k-1];
                pa[k] <= pa[k-1];
            end
        end
    end
    assign mem_rsp_valid_i = pv[LAT-1];
    assign mem_rsp_data_i  = mem_word(pa[LAT-1]);

    // monitor, sampled at the falling edge
    int            nreq, nwr, ndone, busy_err, conflicts, done_cyc;
    logic [AW-1:0] req_addr [LOGN];
    int            req_t    [LOGN];
    logic [IW-1:0] wr_idx   [LOGN];
    logic [DW-1:0] wr_data  [LOGN];
    int            blast    [NB];

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req_valid_o) begin
                if (cyc + 1 - blast[mem_req_addr_o[3:0]] < LAT) conflicts++;
                blast[mem_req_addr_o[3:0]] = cyc + 1;
                if (nreq < LOGN) begin
                    req_addr[nreq] = mem_req_addr_o;
                    req_t[nreq]    = cyc + 1;
                end
                nreq++;
            end
            if (vreg_we_o) begin
                if (nwr < LOGN) begin
                    wr_idx[nwr]  = vreg_idx_o;
                    wr_data[nwr] = vreg_data_o;
                end
                nwr++;
            end
            if (done_o) begin
                if (ndone == 0) done_cyc = cyc;
                ndone++;
                if (busy_o) busy_err++;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic reset_check();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy_o == 1'b0, "R1", "busy after reset", busy_o, 0);
        check(done_o == 1'b0, "R1", "done after reset", done_o, 0);
        check(mem_req_valid_o == 1'b0, "R1", "request after reset", mem_req_valid_o, 0);
        check(vreg_we_o == 1'b0, "R1", "write after reset", vreg_we_o, 0);
    endtask

    task automatic run_load(input logic [AW-1:0] base, input logic [AW-1:0] stride,
                            input int vlen, input bit gath, input logic [MAXV*AW-1:0] idxv,
                            input int intrude, input string a_tag, input string d_tag);
        int n, s, k, prev, t, adr_bad, t_bad, wr_bad, exp_done;
        int last [NB];
        logic [AW-1:0] a;
        n = (vlen > MAXV) ? MAXV : vlen;
        @(negedge clk);
        nreq = 0; nwr = 0; ndone = 0; busy_err = 0; conflicts = 0; done_cyc = -1;
        for (int b = 0; b < NB; b++) blast[b] = -1000;
        base_i = base; stride_i = stride; vlen_i = LW'(vlen); gather_i = gath;
        idx_vec_i = idxv; start_i = 1'b1;
        s = cyc + 1;
        k = 0;
        while (ndone == 0 && k < 3000) begin
            @(negedge clk);
            k++;
            start_i = (intrude != 0) && (k == intrude);
            if (start_i) begin
                base_i = 16'h0800; stride_i = 16'd1; vlen_i = LW'(8); gather_i = 1'b0;
            end
        end
        start_i = 1'b0;
        repeat (LAT + 5) @(negedge clk);

        prev = s; adr_bad = 0; t_bad = 0; wr_bad = 0;
        for (int b = 0; b < NB; b++) last[b] = -1000;
        for (int i = 0; i < n; i++) begin
            a = gath ? AW'(base + idxv[i*AW +: AW]) : AW'(base + AW'(i) * stride);
            t = prev + 1;
            if (last[a[3:0]] + LAT > t) t = last[a[3:0]] + LAT;
            if (i < nreq && req_addr[i] != a) adr_bad++;
            if (i < nreq && req_t[i] != t) t_bad++;
            if (i < nwr && (wr_idx[i] != IW'(i) || wr_data[i] != mem_word(a))) wr_bad++;
            last[a[3:0]] = t;
            prev = t;
        end
        exp_done = (n == 0) ? s + 1 : prev + LAT + 1;

        check(nreq == n, "R4", "request count", nreq, n);
        check(adr_bad == 0, a_tag, "address mismatches", adr_bad, 0);
        check(t_bad == 0, "R4", "request cycles off schedule", t_bad, 0);
        check(conflicts == 0, "R3", "bank reuse inside latency", conflicts, 0);
        check(nwr == n && wr_bad == 0, "R6", "write count / bad writes", nwr * 1000 + wr_bad, n * 1000);
        check(done_cyc == exp_done, d_tag, "done cycle", done_cyc - s, exp_done - s);
        check(ndone == 1 && busy_err == 0, "R7", "done pulses / busy at done", ndone * 10 + busy_err, 10);
        repeat (LAT + 2) @(negedge clk);
    endtask

    task automatic t_unit_stride();    run_load(16'h0040, 16'd1, 16, 1'b0, '0, 0, "R2", "R5"); endtask
    task automatic t_one_bank();       run_load(16'h0005, 16'd16, 3, 1'b0, '0, 0, "R2", "R4"); endtask
    task automatic t_half_banks();     run_load(16'h0000, 16'd2, 16, 1'b0, '0, 0, "R2", "R4"); endtask
    task automatic t_zero_stride();    run_load(16'h0123, 16'd0, 4, 1'b0, '0, 0, "R2", "R4"); endtask
    task automatic t_wrap();           run_load(16'hFFF8, 16'd3, 10, 1'b0, '0, 0, "R2", "R5"); endtask
    task automatic t_zero_len();       run_load(16'h0200, 16'd1, 0, 1'b0, '0, 0, "R2", "R9"); endtask
    task automatic t_clamp();          run_load(16'h0400, 16'd5, 20, 1'b0, '0, 0, "R2", "R10"); endtask
    task automatic t_busy_start();     run_load(16'h0300, 16'd1, 4, 1'b0, '0, 3, "R2", "R11"); endtask

    task automatic t_gather();
        logic [MAXV*AW-1:0] iv;
        for (int i = 0; i < MAXV; i++) iv[i*AW +: AW] = AW'(i * i * 3);
        run_load(16'h0100, 16'd9, 12, 1'b1, iv, 0, "R8", "R4");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < NB; b++) blast[b] = -1000;
        reset_check();
        t_unit_stride();
        t_one_bank();
        t_half_banks();
        t_zero_stride();
        t_wrap();
        t_gather();
        t_zero_len();
        t_clamp();
        t_busy_start();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule